// File: doc/BRIEF.md
# Receive Frame Buffer Segmenter

This block spreads received frames across a ring of fixed-size receive buffers. Bytes arrive on a stream with start-of-frame and end-of-frame markers. Each buffer is owned by a descriptor. A descriptor gives the buffer's base pointer, an empty flag that marks it as ready to be filled, and a wrap flag that closes the ring. The block reads descriptors through a read port that answers in the same cycle. For every accepted byte it issues one memory write. When a buffer is finished, it writes the descriptor back with a length and a last flag. Every write to a descriptor also clears its empty flag.

Software sets a buffer length and pulses `start`. The block checks the length first. It then checks that descriptors 0 and 1 are both empty. If both checks pass, it begins to wait for frames.

The states are named as follows. `ST_IDLE` is the stopped state, and the length check happens there. `ST_CHK` confirms descriptor 1. `ST_WAIT` waits for a start marker. `ST_RECV` fills buffers. `ST_TAIL` closes the data-free final descriptor. `ST_DROP` discards the rest of a frame after an overrun.

The transitions are:
- IDLE to CHK, on a start with a valid length and descriptor 0 empty.
- CHK to WAIT, when descriptor 1 is empty. CHK returns to IDLE otherwise.
- WAIT to RECV, on a start byte.
- RECV to WAIT, on a final close.
- RECV to TAIL, when the end byte exactly fills a buffer.
- TAIL to WAIT, always.
- WAIT or RECV to DROP, when a fresh buffer is not empty.
- DROP to WAIT, on the end byte.

Top module: `rx_frame_segmenter`

## Requirements
- R1: When a byte fills a buffer to exactly `buf_len` bytes, that descriptor is written in the same cycle with length `buf_len` and last = 0.
- R2: The final descriptor of a frame is written with last = 1. Its length is the total number of stream bytes in the frame, which includes the 4 trailing CRC bytes. `frame_done` pulses high for one cycle on that write.
- R3: On `start`, a `buf_len` that is not a multiple of 32, or that is below 64, sets `cfg_err`. In that case `running` stays low and no memory or descriptor write occurs.
- R4: After a valid `start`, reception begins only if descriptor 0 and descriptor 1 both read empty. Otherwise `ring_err` is set and `running` stays low. A later start clears both error flags.
- R5: Byte n of a buffer is written to address (base pointer with its low 5 bits forced to 0) + n. The first byte of each buffer therefore lands on a 32-byte boundary.
- R6: If the frame length is an exact multiple of `buf_len`, one extra descriptor is closed one cycle after the last byte. It has last = 1, the total length, and no memory write.
- R7: After a descriptor with its wrap flag set is closed, the next descriptor used is index 0. Otherwise the next index is the current index + 1, and index NDESC-1 also wraps to 0.
- R8: If the descriptor for a fresh buffer (at frame start, after a full buffer, or for the final data-free descriptor) is not empty, `overrun` pulses. No further writes occur for that frame, and the descriptor index does not advance.
- R9: While waiting for a frame, bytes without a start marker are ignored and cause no writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse: check the configuration and the ring, then begin |
| buf_len | input | LW | Receive buffer length in bytes |
| cfg_err | output | 1 | Buffer length rejected at the last start |
| ring_err | output | 1 | Descriptor 0 or 1 not empty at the last start |
| running | output | 1 | Reception active |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| desc_rd_idx | output | IW | Descriptor index being read |
| desc_rd_base | input | AW | Base pointer of the read descriptor |
| desc_rd_empty | input | 1 | Empty flag of the read descriptor |
| desc_rd_wrap | input | 1 | Wrap flag of the read descriptor |
| desc_wr_en | output | 1 | Descriptor close: write length and last, clear empty |
| desc_wr_idx | output | IW | Index of the descriptor being closed |
| desc_wr_len | output | LW | Length written back |
| desc_wr_last | output | 1 | Last flag written back |
| mem_we | output | 1 | Data write strobe |
| mem_addr | output | AW | Data write address |
| mem_data | output | 8 | Data write byte |
| frame_done | output | 1 | One-cycle pulse when a frame's final descriptor is closed |
| overrun | output | 1 | One-cycle pulse when a frame is dropped for lack of a buffer |

## Verification
The bench builds the block with four descriptors and a buffer length of 64. The wrap flag is set on index 2, so index 3 is never used unless the wrap logic fails, and the ring turns over within three buffers. Short frames of 64 and 128 bytes reach the exact-multiple tail path. A 200-byte frame exhausts the armed buffers mid-frame. Arming only two descriptors starves the data-free tail.

// File: rtl/rxseg_pkg.sv
package rxseg_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHK,
        ST_WAIT,
        ST_RECV,
        ST_TAIL,
        ST_DROP
    } rxseg_state_e;

    localparam int ALIGN_BITS = 5;
    localparam int MIN_BUF    = 64;
endpackage

// File: rtl/rxseg_cfg_check.sv
module rxseg_cfg_check
    import rxseg_pkg::*;
#(
    parameter int LW = 16
) (
    input  logic [LW-1:0] len,
    output logic          ok
);
    localparam logic [LW-1:0] MIN_LEN = LW'(MIN_BUF);

    always_comb begin
        ok = (len[ALIGN_BITS-1:0] == '0) && (len >= MIN_LEN);
    end
endmodule

// File: rtl/rxseg_ring_step.sv
module rxseg_ring_step #(
    parameter int NDESC = 8,
    parameter int IW    = $clog2(NDESC)
) (
    input  logic [IW-1:0] cur,
    input  logic          wrap,
    output logic [IW-1:0] nxt
);
    localparam logic [IW-1:0] LAST_IDX = IW'(NDESC - 1);

    always_comb begin
        if (wrap || cur == LAST_IDX) nxt = '0;
        else                         nxt = cur + 1'b1;
    end
endmodule

// File: rtl/rxseg_addr_gen.sv
module rxseg_addr_gen
    import rxseg_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 16
) (
    input  logic [AW-1:0] base,
    input  logic [LW-1:0] offset,
    output logic [AW-1:0] addr
);
    localparam logic [AW-1:0] LOW_MASK = AW'((1 << ALIGN_BITS) - 1);

    always_comb begin
        addr = (base & ~LOW_MASK) + AW'(offset);
    end
endmodule

// File: rtl/rx_frame_segmenter.sv
module rx_frame_segmenter
    import rxseg_pkg::*;
#(
    parameter int NDESC = 8,
    parameter int AW    = 32,
    parameter int LW    = 16,
    parameter int IW    = $clog2(NDESC)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [LW-1:0] buf_len,
    output logic          cfg_err,
    output logic          ring_err,
    output logic          running,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    input  logic          in_sof,
    input  logic          in_eof,
    output logic [IW-1:0] desc_rd_idx,
    input  logic [AW-1:0] desc_rd_base,
    input  logic          desc_rd_empty,
    input  logic          desc_rd_wrap,
    output logic          desc_wr_en,
    output logic [IW-1:0] desc_wr_idx,
    output logic [LW-1:0] desc_wr_len,
    output logic          desc_wr_last,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_data,
    output logic          frame_done,
    output logic          overrun
);
    rxseg_state_e  state, nxt_state;
    logic [IW-1:0] cur, nxt_cur, step_idx;
    logic [LW-1:0] cnt, nxt_cnt, total, nxt_total, buf_len_q;
    logic [LW-1:0] byte_cnt, tot_base, new_cnt, new_tot;
    logic          cfg_ok, take;

    rxseg_cfg_check #(.LW(LW)) u_cfg (
        .len (buf_len),
        .ok  (cfg_ok)
    );

    rxseg_ring_step #(.NDESC(NDESC), .IW(IW)) u_step (
        .cur  (cur),
        .wrap (desc_rd_wrap),
        .nxt  (step_idx)
    );

    rxseg_addr_gen #(.AW(AW), .LW(LW)) u_addr (
        .base   (desc_rd_base),
        .offset (byte_cnt),
        .addr   (mem_addr)
    );

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cur       <= '0;
            cnt       <= '0;
            total     <= '0;
            buf_len_q <= '0;
            cfg_err   <= 1'b0;
            ring_err  <= 1'b0;
        end else begin
            state <= nxt_state;
            cur   <= nxt_cur;
            cnt   <= nxt_cnt;
            total <= nxt_total;
            if (state == ST_IDLE && start) begin
                buf_len_q <= buf_len;
                cfg_err   <= !cfg_ok;
                ring_err  <= cfg_ok && !desc_rd_empty;
            end
            if (state == ST_CHK) ring_err <= !desc_rd_empty;
        end
    end

    assign running  = (state != ST_IDLE) && (state != ST_CHK);
    assign take     = in_valid && ((state == ST_RECV) || (state == ST_WAIT && in_sof));
    assign byte_cnt = (state == ST_WAIT) ? '0 : cnt;
    assign tot_base = (state == ST_WAIT) ? '0 : total;
    assign new_cnt  = byte_cnt + 1'b1;
    assign new_tot  = tot_base + 1'b1;
    assign mem_data = in_data;

    // next-state and output process
    always_comb begin
        nxt_state    = state;
        nxt_cur      = cur;
        nxt_cnt      = cnt;
        nxt_total    = total;
        desc_rd_idx  = cur;
        desc_wr_idx  = cur;
        desc_wr_en   = 1'b0;
        desc_wr_len  = buf_len_q;
        desc_wr_last = 1'b0;
        mem_we       = 1'b0;
        frame_done   = 1'b0;
        overrun      = 1'b0;
        unique case (state)
            ST_IDLE: begin
                desc_rd_idx = '0;
                if (start && cfg_ok && desc_rd_empty) nxt_state = ST_CHK;
            end
            ST_CHK: begin
                desc_rd_idx = IW'(1);
                nxt_cur     = '0;
                nxt_state   = desc_rd_empty ? ST_WAIT : ST_IDLE;
            end
            ST_WAIT, ST_RECV: begin
                if (take) begin
                    if (byte_cnt == '0 && !desc_rd_empty) begin
                        overrun   = 1'b1;
                        nxt_state = in_eof ? ST_WAIT : ST_DROP;
                    end else begin
                        mem_we = 1'b1;
                        if (new_cnt == buf_len_q) begin
                            desc_wr_en = 1'b1;
                            nxt_cur    = step_idx;
                            nxt_cnt    = '0;
                            nxt_total  = new_tot;
                            nxt_state  = in_eof ? ST_TAIL : ST_RECV;
                        end else if (in_eof) begin
                            desc_wr_en   = 1'b1;
                            desc_wr_last = 1'b1;
                            desc_wr_len  = new_tot;
                            frame_done   = 1'b1;
                            nxt_cur      = step_idx;
                            nxt_cnt      = '0;
                            nxt_state    = ST_WAIT;
                        end else begin
                            nxt_cnt   = new_cnt;
                            nxt_total = new_tot;
                            nxt_state = ST_RECV;
                        end
                    end
                end
            end
            ST_TAIL: begin
                nxt_state = ST_WAIT;
                if (desc_rd_empty) begin
                    desc_wr_en   = 1'b1;
                    desc_wr_last = 1'b1;
                    desc_wr_len  = total;
                    frame_done   = 1'b1;
                    nxt_cur      = step_idx;
                end else begin
                    overrun = 1'b1;
                end
            end
            ST_DROP: begin
                if (in_valid && in_eof) nxt_state = ST_WAIT;
            end
        endcase
    end

    // A buffer close that is not final always coincides with a byte write (R1)
    assert_full_close_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_wr_en && !desc_wr_last) |-> (mem_we && in_valid));

    // Completion pulse only on a final close (R2)
    assert_done_is_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (desc_wr_en && desc_wr_last));

    // Nothing is written while stopped (R3)
    assert_no_write_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (!mem_we && !desc_wr_en));

    // First byte of a frame lands on an aligned address (R5)
    assert_addr_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && in_sof) |-> (mem_addr[ALIGN_BITS-1:0] == '0));

    // End byte that fills a buffer is followed by a tail close or an overrun (R6)
    assert_tail_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_wr_en && !desc_wr_last && in_eof) |=> ((desc_wr_en && desc_wr_last && !mem_we) || overrun));

    // Closing a wrap-flagged descriptor returns the ring to index 0 (R7)
    assert_wrap_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_wr_en && desc_rd_wrap) |=> (desc_rd_idx == '0));

    // An overrun cycle writes nothing (R8)
    assert_overrun_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> (!mem_we && !desc_wr_en));
endmodule

// File: tb/rx_frame_segmenter_bench.sv
module rx_frame_segmenter_bench;
    localparam int NDESC  = 4;
    localparam int AW     = 32;
    localparam int LW     = 16;
    localparam int IW     = 2;
    localparam int BUFLEN = 64;
    localparam logic [NDESC-1:0] D_WRAP = 4'b0100;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n, start, in_valid, in_sof, in_eof;
    logic [LW-1:0] buf_len;
    logic [7:0]    in_data;
    logic          cfg_err, ring_err, running;
    logic [IW-1:0] desc_rd_idx, desc_wr_idx;
    logic [AW-1:0] desc_rd_base, mem_addr;
    logic          desc_rd_empty, desc_rd_wrap, desc_wr_en, desc_wr_last;
    logic [LW-1:0] desc_wr_len;
    logic          mem_we, frame_done, overrun;
    logic [7:0]    mem_data;

    rx_frame_segmenter #(.NDESC(NDESC), .AW(AW), .LW(LW), .IW(IW)) u_rx_frame_segmenter (
        .clk(clk), .rst_n(rst_n), .start(start), .buf_len(buf_len),
        .cfg_err(cfg_err), .ring_err(ring_err), .running(running),
        .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
        .desc_rd_idx(desc_rd_idx), .desc_rd_base(desc_rd_base),
        .desc_rd_empty(desc_rd_empty), .desc_rd_wrap(desc_rd_wrap),
        .desc_wr_en(desc_wr_en), .desc_wr_idx(desc_wr_idx), .desc_wr_len(desc_wr_len),
        .desc_wr_last(desc_wr_last), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_data(mem_data), .frame_done(frame_done), .overrun(overrun)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] base_of(input int i);
        return AW'(32'h0001_0000 + i * 32'h400 + i * 5);
    endfunction

    // descriptor store seen by the block
    logic [NDESC-1:0] d_empty;
    logic [NDESC-1:0] arm_req = '0;
    assign desc_rd_base  = base_of(int'(desc_rd_idx));
    assign desc_rd_empty = d_empty[desc_rd_idx];
    assign desc_rd_wrap  = D_WRAP[desc_rd_idx];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) d_empty <= '0;
        else begin
            for (int i = 0; i < NDESC; i++) if (arm_req[i]) d_empty[i] <= 1'b1;
            if (desc_wr_en) d_empty[desc_wr_idx] <= 1'b0;
        end
    end

    // reference model state
    bit [NDESC-1:0] m_empty = '0;
    int             m_cur   = 0;
    logic [39:0]    exp_mem[$];
    int             exp_desc[$];
    string          exp_tag[$];
    int exp_done = 0, exp_busy = 0, got_done = 0, got_busy = 0;

    function automatic int adv(input int c);
        if (D_WRAP[c] || c == NDESC - 1) return 0;
        return c + 1;
    endfunction

    // per-clock comparison against the expected event stream
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_we) begin
                if (exp_mem.size() == 0) chk(0, "R9 unexpected write", longint'(mem_addr), 0);
                else begin
                    logic [39:0] e;
                    e = exp_mem.pop_front();
                    chk({mem_addr, mem_data} == e, "R5 write addr/data", longint'({mem_addr, mem_data}), longint'(e));
                end
            end
            if (desc_wr_en) begin
                int got;
                got = (int'(desc_wr_idx) << 20) | (int'(desc_wr_last) << 16) | int'(desc_wr_len);
                if (exp_desc.size() == 0) chk(0, "R8 unexpected close", got, 0);
                else begin
                    int e;
                    string t;
                    e = exp_desc.pop_front();
                    t = exp_tag.pop_front();
                    chk(got == e, {t, " close idx/last/len"}, got, e);
                end
            end
            if (frame_done) got_done++;
            if (overrun) got_busy++;
        end
    end

    task automatic arm(input bit [NDESC-1:0] mask);
        arm_req = mask;
        m_empty |= mask;
        @(posedge clk); #1;
        arm_req = '0;
    endtask

    function automatic logic [7:0] byte_of(input int f, input int k);
        return 8'((f * 37 + k * 3) & 255);
    endfunction

    task automatic model_frame(input int f, input int len);
        bit dropped = 0;
        for (int k = 0; k < len; k++) begin
            int off;
            off = k % BUFLEN;
            if (off == 0 && !m_empty[m_cur]) begin
                exp_busy++;
                dropped = 1;
                break;
            end
            exp_mem.push_back({(base_of(m_cur) & ~AW'(31)) + AW'(off), byte_of(f, k)});
            if (off == BUFLEN - 1) begin
                exp_desc.push_back((m_cur << 20) | BUFLEN);
                exp_tag.push_back("R1");
                m_empty[m_cur] = 0;
                m_cur = adv(m_cur);
            end else if (k == len - 1) begin
                exp_desc.push_back((m_cur << 20) | (1 << 16) | len);
                exp_tag.push_back("R2");
                m_empty[m_cur] = 0;
                m_cur = adv(m_cur);
                exp_done++;
            end
        end
        if (!dropped && len % BUFLEN == 0) begin
            if (m_empty[m_cur]) begin
                exp_desc.push_back((m_cur << 20) | (1 << 16) | len);
                exp_tag.push_back("R6");
                m_empty[m_cur] = 0;
                m_cur = adv(m_cur);
                exp_done++;
            end else exp_busy++;
        end
    endtask

    task automatic send_frame(input int f, input int len);
        model_frame(f, len);
        for (int k = 0; k < len; k++) begin
            @(posedge clk); #1;
            in_valid = 1'b1;
            in_data  = byte_of(f, k);
            in_sof   = (k == 0);
            in_eof   = (k == len - 1);
        end
        @(posedge clk); #1;
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        chk(exp_mem.size() == 0, "R5 writes outstanding", exp_mem.size(), 0);
        chk(exp_desc.size() == 0, "R7 closes outstanding", exp_desc.size(), 0);
        chk(got_done == exp_done, "R2 frame_done count", got_done, exp_done);
        chk(got_busy == exp_busy, "R8 overrun count", got_busy, exp_busy);
    endtask

    task automatic do_start(input int len);
        @(posedge clk); #1;
        buf_len = LW'(len);
        start   = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        repeat (3) @(posedge clk);
        #1;
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; buf_len = '0;
        in_valid = 1'b0; in_data = '0; in_sof = 1'b0; in_eof = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk(!running && !cfg_err && !ring_err, "R3 reset state", {running, cfg_err, ring_err}, 0);
        chk(!mem_we && !desc_wr_en, "R3 reset writes", {mem_we, desc_wr_en}, 0);
        rst_n = 1'b1;

        do_start(80);
        chk(cfg_err && !running, "R3 length not multiple of 32", {cfg_err, running}, 2'b10);
        do_start(32);
        chk(cfg_err && !running, "R3 length below 64", {cfg_err, running}, 2'b10);
        do_start(BUFLEN);
        chk(!cfg_err && ring_err && !running, "R4 descriptor 0 busy", {cfg_err, ring_err, running}, 3'b010);
        arm(4'b0001);
        do_start(BUFLEN);
        chk(ring_err && !running, "R4 descriptor 1 busy", {ring_err, running}, 2'b10);
        arm('1);
        do_start(BUFLEN);
        chk(running && !ring_err && !cfg_err, "R4 start with two ready", {running, ring_err, cfg_err}, 3'b100);

        // r9_: stray bytes with no start marker while waiting
        for (int k = 0; k < 3; k++) begin
            @(posedge clk); #1;
            in_valid = 1'b1; in_data = 8'(k); in_sof = 1'b0; in_eof = (k == 2);
        end
        @(posedge clk); #1;
        in_valid = 1'b0; in_eof = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        chk(exp_mem.size() == 0 && got_done == 0, "R9 stray bytes ignored", got_done, 0);

        send_frame(1, 1);     arm('1);
        send_frame(2, 64);    arm('1);
        send_frame(3, 65);    arm('1);
        send_frame(4, 128);   arm('1);
        send_frame(5, 130);   arm('1);
        send_frame(6, 63);    arm('1);
        send_frame(7, 200);               // overrun mid-frame (R8)
        send_frame(8, 64);                // overrun at frame start (R8)
        arm('0);
        begin
            bit [NDESC-1:0] m;
            m = '0;
            m[m_cur] = 1'b1;
            m[adv(m_cur)] = 1'b1;
            arm(m);
        end
        send_frame(9, 128);               // tail descriptor missing (R6, R8)
        arm('1);
        send_frame(10, 70);               // recovery after overruns (R7)

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule